// File: doc/BRIEF.md
# H-Bridge Protection and Power-State Supervisor

This block decides, every clock cycle, whether a motor H-bridge output stage may be driven. It watches a functional reset pin, a sleep request pin, one current-limit flag per power FET, an over-temperature flag and a supply-undervoltage flag. From these it drives the bridge enable, the charge-pump and regulator enable, the enable for the internal clocks, a ready indication and an active-low fault output. It also gates the step/direction style command inputs so that they reach the indexer only when the logic is operational.

Each condition is handled differently. An undervoltage wipes all state. The reset pin clears the logic. Sleep powers down and is followed by a timed wake-up delay. A qualified overcurrent latches until reset or a supply cycle. An over-temperature fault clears itself. All pin and flag inputs pass through two synchronizer flops. The outputs come from a single register stage, so every input change reaches the outputs on the third rising clock edge.

Top module: `hbridge_guard`

## Requirements
- R1: While the synchronized reset pin is low (and no undervoltage), bridge_en=0, ready=0, fault_n=1, pump_en=1, clk_en=1 and cmd_out=0. Reset also clears a latched overcurrent fault and any pending wake-up count.
- R2: While the synchronized sleep pin is low (no undervoltage, reset pin high), bridge_en, pump_en, clk_en and ready are 0, fault_n=1 and cmd_out=0.
- R3: After sleep_n returns high, bridge_en and ready stay 0 for WAKE_CYC further cycles. ready first reads 1 right after rising edge WAKE_CYC+3 counted from the release. During the wake-up interval pump_en=1, clk_en=1 and fault_n=1.
- R4: If any current-limit flag is high for OCP_QUAL_CYC+1 or more consecutive sampled cycles, an overcurrent fault latches: bridge_en=0 and fault_n=0, while pump_en, clk_en and ready stay 1. A run of OCP_QUAL_CYC cycles or shorter never latches, because the qualification count restarts whenever all flags are low.
- R5: A latched overcurrent fault survives its flag dropping, an over-temperature episode that starts and ends while it is latched, and a sleep/wake cycle. Only the reset pin or an undervoltage clears it.
- R6: Every bit of the current-limit flag vector (high-side or low-side FET) leads to the same shutdown.
- R7: While the over-temperature flag is high (and nothing of higher priority applies), bridge_en=0 and fault_n=0 with ready=1. Normal operation returns by itself when the flag drops.
- R8: While the undervoltage flag is high, bridge_en, pump_en, clk_en, ready and cmd_out are 0 and fault_n=1, and any latched overcurrent is cleared. Operation resumes when the flag drops.
- R9: Priority from highest to lowest: undervoltage, reset pin, sleep (including the wake-up interval), latched overcurrent, over-temperature, normal run. In normal run bridge_en, pump_en, clk_en, ready and fault_n are all 1.
- R10: Any input change appears at the outputs after exactly three rising edges: two synchronizer stages and one output register.
- R11: cmd_out equals the command input delayed by three edges whenever ready is 1, and is all zeros otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Chip power-on reset, asynchronous assert, active low |
| pin_rst_n | input | 1 | Functional reset pin, active low, asynchronous |
| sleep_n | input | 1 | Sleep request pin, active low, asynchronous |
| ilim | input | NUM_FET | Per-FET current-limit flags, active high |
| otemp | input | 1 | Over-temperature flag, active high |
| uvolt | input | 1 | Supply undervoltage flag, active high |
| cmd_in | input | CMD_W | Raw command inputs (step, direction, ...) |
| bridge_en | output | 1 | Bridge FETs may be driven |
| pump_en | output | 1 | Charge pump and regulator enable |
| clk_en | output | 1 | Internal clock enable |
| ready | output | 1 | Logic operational, commands accepted |
| fault_n | output | 1 | Registered fault indication, active low |
| cmd_out | output | CMD_W | Gated, synchronized commands |

## Verification
The assertions check these on every cycle: a latched overcurrent stays latched unless cleared, it only sets when the qualification count has reached its limit, the wake-up counter steps down by one, an undervoltage or sleep darkens the power enables one cycle later, and the bridge is never enabled without ready and an inactive fault. Three things need the bench's scenarios: the exact pulse width at which a current-limit run latches on each FET, the exact wake-up latency in edges, and whether the latch survives a whole sweep of overlapping reset, sleep, thermal and undervoltage combinations followed by a return to normal.

// File: rtl/hbg_pkg.sv
package hbg_pkg;

  typedef enum logic [2:0] {
    MODE_UVLO    = 3'd0,
    MODE_RESET   = 3'd1,
    MODE_SLEEP   = 3'd2,
    MODE_WAKE    = 3'd3,
    MODE_OCLATCH = 3'd4,
    MODE_THERMAL = 3'd5,
    MODE_RUN     = 3'd6
  } hbg_mode_e;

  typedef struct packed {
    logic bridge;
    logic pump;
    logic clk;
    logic ready;
    logic fault_n;
  } hbg_out_t;

  localparam hbg_out_t OUT_RESET_VAL = '{bridge: 1'b0, pump: 1'b0, clk: 1'b0,
                                         ready: 1'b0, fault_n: 1'b1};

  function automatic hbg_out_t mode_outputs(hbg_mode_e m);
    hbg_out_t o;
    o = OUT_RESET_VAL;
    case (m)
      MODE_UVLO:    o = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
      MODE_RESET:   o = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
      MODE_SLEEP:   o = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1};
      MODE_WAKE:    o = '{1'b0, 1'b1, 1'b1, 1'b0, 1'b1};
      MODE_OCLATCH: o = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
      MODE_THERMAL: o = '{1'b0, 1'b1, 1'b1, 1'b1, 1'b0};
      MODE_RUN:     o = '{1'b1, 1'b1, 1'b1, 1'b1, 1'b1};
      default:      o = OUT_RESET_VAL;
    endcase
    return o;
  endfunction

endpackage

// File: rtl/hbg_sync.sv
module hbg_sync #(
  parameter int unsigned       W       = 1,
  parameter logic [W-1:0]      RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic stage1;
    logic stage2;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage1 <= RST_VAL[i];
        stage2 <= RST_VAL[i];
      end else begin
        stage1 <= d[i];
        stage2 <= stage1;
      end
    end

    assign q[i] = stage2;
  end

endmodule

// File: rtl/hbg_ocp_qual.sv
module hbg_ocp_qual #(
  parameter int unsigned NUM_FET  = 4,
  parameter int unsigned QUAL_CYC = 100
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               hold,
  input  logic [NUM_FET-1:0] ilim,
  output logic               latched
);

  localparam int unsigned CW = $clog2(QUAL_CYC + 1);
  localparam logic [CW-1:0] QUAL_MAX = CW'(QUAL_CYC);

  logic          any_lim;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          lat_q, lat_d;
  logic          cnt_en;

  assign any_lim = |ilim;
  assign cnt_en  = !clr && !hold && !lat_q;

  always_comb begin
    cnt_d = cnt_q;
    lat_d = lat_q;
    if (clr) begin
      cnt_d = '0;
      lat_d = 1'b0;
    end else if (!cnt_en || !any_lim) begin
      cnt_d = '0;
    end else if (cnt_q == QUAL_MAX) begin
      lat_d = 1'b1;
      cnt_d = '0;
    end else begin
      cnt_d = cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      lat_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      lat_q <= lat_d;
    end
  end

  assign latched = lat_q;

  AST_LATCH_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (lat_q && !clr) |=> lat_q); // R5

  AST_NO_EARLY_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lat_q) |-> ($past(cnt_q) == QUAL_MAX)); // R4

endmodule

// File: rtl/hbg_wake_timer.sv
module hbg_wake_timer #(
  parameter int unsigned WAKE_CYC = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic load,
  output logic busy
);

  localparam int unsigned CW = $clog2(WAKE_CYC + 1);
  localparam logic [CW-1:0] WAKE_MAX = CW'(WAKE_CYC);

  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (clr)
      cnt_d = '0;
    else if (load)
      cnt_d = WAKE_MAX;
    else if (cnt_q != '0)
      cnt_d = cnt_q - CW'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign busy = (cnt_q != '0);

  AST_WAKE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !clr && !load) |=> (cnt_q == $past(cnt_q) - CW'(1))); // R3

  AST_WAKE_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !load) |=> !busy); // R3

endmodule

// File: rtl/hbridge_guard.sv
module hbridge_guard
  import hbg_pkg::*;
#(
  parameter int unsigned NUM_FET      = 4,
  parameter int unsigned CMD_W        = 2,
  parameter int unsigned OCP_QUAL_CYC = 100,
  parameter int unsigned WAKE_CYC     = 50000
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               pin_rst_n,
  input  logic               sleep_n,
  input  logic [NUM_FET-1:0] ilim,
  input  logic               otemp,
  input  logic               uvolt,
  input  logic [CMD_W-1:0]   cmd_in,
  output logic               bridge_en,
  output logic               pump_en,
  output logic               clk_en,
  output logic               ready,
  output logic               fault_n,
  output logic [CMD_W-1:0]   cmd_out
);

  logic               s_rst_n, s_sleep_n, s_uv, s_ot;
  logic [NUM_FET-1:0] s_ilim;
  logic [CMD_W-1:0]   s_cmd;

  hbg_sync #(.W(1), .RST_VAL(1'b0)) u_sync_rst (
    .clk(clk), .rst_n(rst_n), .d(pin_rst_n), .q(s_rst_n));
  hbg_sync #(.W(1), .RST_VAL(1'b1)) u_sync_slp (
    .clk(clk), .rst_n(rst_n), .d(sleep_n), .q(s_sleep_n));
  hbg_sync #(.W(1), .RST_VAL(1'b1)) u_sync_uv (
    .clk(clk), .rst_n(rst_n), .d(uvolt), .q(s_uv));
  hbg_sync #(.W(1), .RST_VAL(1'b0)) u_sync_ot (
    .clk(clk), .rst_n(rst_n), .d(otemp), .q(s_ot));
  hbg_sync #(.W(NUM_FET), .RST_VAL('0)) u_sync_ilim (
    .clk(clk), .rst_n(rst_n), .d(ilim), .q(s_ilim));
  hbg_sync #(.W(CMD_W), .RST_VAL('0)) u_sync_cmd (
    .clk(clk), .rst_n(rst_n), .d(cmd_in), .q(s_cmd));

  hbg_mode_e mode;
  logic      wake_busy;
  logic      ocp_latched;
  logic      state_clr;
  logic      qual_hold;

  assign state_clr = s_uv || !s_rst_n;
  assign qual_hold = (mode != MODE_RUN) && (mode != MODE_THERMAL);

  hbg_wake_timer #(.WAKE_CYC(WAKE_CYC)) u_wake (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (state_clr),
    .load (mode == MODE_SLEEP),
    .busy (wake_busy)
  );

  hbg_ocp_qual #(.NUM_FET(NUM_FET), .QUAL_CYC(OCP_QUAL_CYC)) u_ocp (
    .clk    (clk),
    .rst_n  (rst_n),
    .clr    (state_clr),
    .hold   (qual_hold),
    .ilim   (s_ilim),
    .latched(ocp_latched)
  );

  // priority chain: highest condition wins in the same cycle
  always_comb begin
    if (s_uv)             mode = MODE_UVLO;
    else if (!s_rst_n)    mode = MODE_RESET;
    else if (!s_sleep_n)  mode = MODE_SLEEP;
    else if (wake_busy)   mode = MODE_WAKE;
    else if (ocp_latched) mode = MODE_OCLATCH;
    else if (s_ot)        mode = MODE_THERMAL;
    else                  mode = MODE_RUN;
  end

  hbg_out_t           out_d, out_q;
  logic [CMD_W-1:0]   cmd_d, cmd_q;

  always_comb begin
    out_d = mode_outputs(mode);
    cmd_d = out_d.ready ? s_cmd : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= OUT_RESET_VAL;
      cmd_q <= '0;
    end else begin
      out_q <= out_d;
      cmd_q <= cmd_d;
    end
  end

  assign bridge_en = out_q.bridge;
  assign pump_en   = out_q.pump;
  assign clk_en    = out_q.clk;
  assign ready     = out_q.ready;
  assign fault_n   = out_q.fault_n;
  assign cmd_out   = cmd_q;

  AST_BRIDGE_NEEDS_READY: assert property (@(posedge clk) disable iff (!rst_n)
    bridge_en |-> (ready && fault_n)); // R9

  AST_UV_DARK: assert property (@(posedge clk) disable iff (!rst_n)
    $past(s_uv) |-> (!pump_en && !bridge_en && !ready && fault_n)); // R8

  AST_SLEEP_POWERDOWN: assert property (@(posedge clk) disable iff (!rst_n)
    $past(!s_uv && s_rst_n && !s_sleep_n) |-> (!pump_en && !clk_en)); // R2

  AST_LATCH_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ocp_latched && !s_uv && s_rst_n && s_sleep_n && !wake_busy)
      |-> (!fault_n && !bridge_en)); // R4

  AST_CMD_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |-> (cmd_out == '0)); // R11

endmodule

// File: tb/hbridge_guard_bench.sv
module hbridge_guard_bench;

  localparam int NF   = 4;
  localparam int CW   = 3;
  localparam int QUAL = 5;
  localparam int WAKE = 6;
  localparam logic [CW-1:0] CMD_PAT = 3'b101;

  logic          clk;
  logic          rst_n;
  logic          pin_rst_n, sleep_n, otemp, uvolt;
  logic [NF-1:0] ilim;
  logic [CW-1:0] cmd_in;
  logic          bridge_en, pump_en, clk_en, ready, fault_n;
  logic [CW-1:0] cmd_out;

  int n_vec;
  int n_bad;

  hbridge_guard #(
    .NUM_FET(NF), .CMD_W(CW), .OCP_QUAL_CYC(QUAL), .WAKE_CYC(WAKE)
  ) u_hbridge_guard (
    .clk(clk), .rst_n(rst_n), .pin_rst_n(pin_rst_n), .sleep_n(sleep_n),
    .ilim(ilim), .otemp(otemp), .uvolt(uvolt), .cmd_in(cmd_in),
    .bridge_en(bridge_en), .pump_en(pump_en), .clk_en(clk_en),
    .ready(ready), .fault_n(fault_n), .cmd_out(cmd_out)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  // observed vector: {bridge, pump, clk, ready, fault_n, cmd[2:0]}
  function automatic logic [7:0] obs();
    return {bridge_en, pump_en, clk_en, ready, fault_n, cmd_out};
  endfunction

  function automatic logic [7:0] expect_f(logic uv, logic rn, logic sn,
                                          logic lat, logic ot, logic [CW-1:0] c);
    logic [4:0] o;
    if (uv)       o = 5'b00001;
    else if (!rn) o = 5'b01101;
    else if (!sn) o = 5'b00001;
    else if (lat) o = 5'b01110;
    else if (ot)  o = 5'b01110;
    else          o = 5'b11111;
    return {o, (o[1] ? c : 3'b000)};
  endfunction

  task automatic step(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic to_normal();
    uvolt = 1'b0; pin_rst_n = 1'b1; sleep_n = 1'b1; otemp = 1'b0; ilim = '0;
  endtask

  task automatic clean();
    to_normal();
    pin_rst_n = 1'b0;
    step(4);
    pin_rst_n = 1'b1;
    step(WAKE + 6);
  endtask

  task automatic make_latch(int idx);
    ilim[idx] = 1'b1;
    step(QUAL + 2);
    ilim = '0;
    step(4);
  endtask

  task automatic summary();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    n_vec = 0; n_bad = 0;
    rst_n = 1'b0;
    cmd_in = CMD_PAT;
    to_normal();
    pin_rst_n = 1'b0;
    step(3);
    chk("R1 chip reset", obs(), 8'b00001_000);
    rst_n = 1'b1;
    step(4);
    chk("R1 pin reset", obs(), expect_f(0, 0, 1, 0, 0, CMD_PAT));
    pin_rst_n = 1'b1;
    step(5);
    chk("R9 run", obs(), expect_f(0, 1, 1, 0, 0, CMD_PAT));

    // R10 / R11: latency of a command change and of a thermal flag
    cmd_in = 3'b010;
    step(2);
    chk("R10 cmd not yet", obs(), expect_f(0, 1, 1, 0, 0, CMD_PAT));
    step(1);
    chk("R11 cmd passes", obs(), expect_f(0, 1, 1, 0, 0, 3'b010));
    cmd_in = CMD_PAT;
    step(4);
    otemp = 1'b1;
    step(2);
    chk("R10 ot not yet", obs(), expect_f(0, 1, 1, 0, 0, CMD_PAT));
    step(1);
    chk("R7 ot fault", obs(), expect_f(0, 1, 1, 0, 1, CMD_PAT));
    otemp = 1'b0;
    step(3);
    chk("R7 auto resume", obs(), expect_f(0, 1, 1, 0, 0, CMD_PAT));

    // R3: exact wake-up latency
    sleep_n = 1'b0;
    step(4);
    chk("R2 sleep", obs(), expect_f(0, 1, 0, 0, 0, CMD_PAT));
    sleep_n = 1'b1;
    begin
      int edges;
      logic early;
      edges = 0;
      early = 1'b0;
      while (!ready && edges < 100) begin
        step(1);
        edges++;
        if (bridge_en && !ready) early = 1'b1;
      end
      chk("R3 wake edges", 8'(edges), 8'(WAKE + 3));
      chk("R3 no early bridge", {7'd0, early}, 8'd0);
    end

    // R4 / R6: pulse width sweep on every FET flag
    for (int f = 0; f < NF; f++) begin
      for (int w = 1; w <= QUAL + 2; w++) begin
        clean();
        ilim[f] = 1'b1;
        step(w);
        ilim = '0;
        step(5);
        chk($sformatf("R4 R6 fet%0d width%0d", f, w), obs(),
            expect_f(0, 1, 1, (w > QUAL), 0, CMD_PAT));
      end
    end

    // R5 / R8 / R1 / R9: priority sweep with and without a latched fault
    for (int lat = 0; lat < 2; lat++) begin
      for (int combo = 0; combo < 16; combo++) begin
        logic uv, rn, sn, ot, kept;
        uv = combo[3]; rn = combo[2]; sn = combo[1]; ot = combo[0];
        clean();
        if (lat == 1) make_latch(combo % NF);
        uvolt = uv; pin_rst_n = rn; sleep_n = sn; otemp = ot;
        step(WAKE + 6);
        chk($sformatf("R9 prio lat%0d combo%0d", lat, combo), obs(),
            expect_f(uv, rn, sn, lat[0], ot, CMD_PAT));
        kept = lat[0] && !uv && rn;
        to_normal();
        step(WAKE + 6);
        chk($sformatf("R5 R8 R1 retain lat%0d combo%0d", lat, combo), obs(),
            expect_f(0, 1, 1, kept, 0, CMD_PAT));
      end
    end

    summary();
  end

endmodule